// File: doc/BRIEF.md
# Instruction-Level Energy Accumulator

This block turns a stream of retired instruction descriptors into a running energy estimate. Each cycle it may receive one descriptor, marked by a valid strobe. A descriptor carries an arithmetic-operation key, a parallel-move key, and a flag that says whether an arithmetic part is present. Four accounting units each look up a cost for their own key: the data ALU, the address unit, program control, and the remaining clock-and-bus logic. A unit always charges its base cost. It also charges a one-entry-per-key overhead, but only when its key differs from the key it saw on the previous counted cycle. The overhead depends on the new instruction alone, not on the pair, so each table grows linearly with the number of keys.

The data ALU and program-control units take their key from the arithmetic part. When no arithmetic part is present they take it from the move part. The address and clock-and-bus units use only the move part. Software loads every cost table through a simple write port. The block reports the four unit totals, the grand total and the number of counted cycles. On request, a sequential divider produces the average energy per cycle and scales it by a supplied cycles-per-datum value to give energy per datum.

Top module: `insn_energy_meter`

## Requirements
- R1: After reset, all four unit totals, the grand total, the cycle count, `avg_busy`, `avg_done`, `avg_energy` and `datum_energy` are zero, and every table entry is zero.
- R2: On each cycle with `in_valid` high, every unit adds the base cost stored at its current table index to its total. The new total is visible after that clock edge.
- R3: A unit also adds the overhead cost at its index when that index differs from the index it used on its previous counted cycle. The first counted cycle after reset always adds the overhead.
- R4: The data ALU and program-control units use index {0, `arith_key`} when `arith_present` is 1 and index {1, `move_key`} when it is 0. The index is the most significant bit followed by the key. Moving between an arithmetic key and a move key with the same number therefore counts as a change.
- R5: The address and clock-and-bus units use index {0, `move_key`}. `arith_key` and `arith_present` have no effect on their totals.
- R6: A cycle with `in_valid` low changes no total and does not change the cycle count. It also does not change the remembered previous index of any unit.
- R7: `energy_total` equals the sum of all four units' per-cycle charges. `cycle_count` increases by one on each counted cycle and stops at its maximum value.
- R8: Every unit total and the grand total stop at the maximum value of their width (all ones) instead of wrapping.
- R9: A write with `tbl_we` high stores `tbl_data` into table `tbl_unit` at `tbl_addr`. The unit codes are 0 = data ALU, 1 = address unit, 2 = program control, 3 = clock and bus. `tbl_kind` 0 selects the base table and 1 selects the overhead table. The new value applies to descriptors from the next cycle onward.
- R10: A pulse on `avg_start` while `avg_busy` is low captures the grand total and the cycle count, and clears `avg_done`. The divider then raises `avg_busy`, and later raises `avg_done` with `avg_energy` = floor(total / count). When the count is zero, the result is 0 and `avg_done` rises one cycle after the start. A start while busy is ignored. The result holds until the next accepted start.
- R11: `datum_energy` equals `avg_energy` multiplied by the `cyc_per_datum` value sampled at the accepted start. It becomes valid together with `avg_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Descriptor present this cycle |
| arith_present | input | 1 | Descriptor has an arithmetic part |
| arith_key | input | KEY_W | Arithmetic-operation key |
| move_key | input | KEY_W | Parallel-move key |
| tbl_we | input | 1 | Table write strobe |
| tbl_unit | input | 2 | Unit whose table is written |
| tbl_kind | input | 1 | 0 base table, 1 overhead table |
| tbl_addr | input | KEY_W+1 | Table index written |
| tbl_data | input | COST_W | Cost value written |
| avg_start | input | 1 | Start average computation |
| cyc_per_datum | input | CPD_W | Cycles per output datum |
| energy_alu | output | ACC_W | Data ALU total |
| energy_agu | output | ACC_W | Address unit total |
| energy_pcu | output | ACC_W | Program control total |
| energy_oth | output | ACC_W | Clock and bus total |
| energy_total | output | ACC_W | Grand total |
| cycle_count | output | CNT_W | Counted cycles |
| avg_busy | output | 1 | Divider running |
| avg_done | output | 1 | Average result valid |
| avg_energy | output | ACC_W | Average energy per cycle |
| datum_energy | output | ACC_W+CPD_W | Energy per datum |

## Verification
The assertions assume that `avg_start` is only a short pulse. They also assume that the count and the totals are not fed from outside, so the grand total can only grow between resets, and the bench resets the block before each phase. No assertion relies on the table contents. The bench loads tables that keep the unsaturated phase well below the accumulator limit. It then moves to all-maximum tables in a separate phase after a reset, where saturation is reached on purpose. The stimulus pulses `avg_start` once while the divider is idle and waits for `avg_done` before changing any descriptor inputs.

// File: rtl/energy_pkg.sv
package energy_pkg;
    localparam int NUM_UNITS = 4;

    typedef enum logic [1:0] {
        UNIT_ALU = 2'd0,
        UNIT_AGU = 2'd1,
        UNIT_PCU = 2'd2,
        UNIT_OTH = 2'd3
    } unit_e;

    // unit charged from the arithmetic half (with move fallback)
    function automatic logic uses_arith(input int unit);
        return (unit == int'(UNIT_ALU)) || (unit == int'(UNIT_PCU));
    endfunction
endpackage

// File: rtl/energy_cost_table.sv
module energy_cost_table #(
    parameter int IDX_W  = 3,
    parameter int COST_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic              kind,
    input  logic [IDX_W-1:0]  waddr,
    input  logic [COST_W-1:0] wdata,
    input  logic [IDX_W-1:0]  raddr,
    output logic [COST_W-1:0] base_cost,
    output logic [COST_W-1:0] ovh_cost
);
    localparam int DEPTH = 1 << IDX_W;

    typedef struct packed {
        logic [DEPTH-1:0][COST_W-1:0] base;
        logic [DEPTH-1:0][COST_W-1:0] ovh;
    } tbl_t;

    tbl_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (we) begin
            if (kind) s_d.ovh[waddr]  = wdata;
            else      s_d.base[waddr] = wdata;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign base_cost = s_q.base[raddr];
    assign ovh_cost  = s_q.ovh[raddr];
endmodule

// File: rtl/energy_unit_acc.sv
module energy_unit_acc #(
    parameter int IDX_W  = 3,
    parameter int COST_W = 16,
    parameter int ACC_W  = 40
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              valid,
    input  logic [IDX_W-1:0]  idx,
    input  logic [COST_W-1:0] base_cost,
    input  logic [COST_W-1:0] ovh_cost,
    output logic [COST_W:0]   charge,
    output logic [ACC_W-1:0]  acc
);
    typedef struct packed {
        logic [ACC_W-1:0] acc;
        logic [IDX_W-1:0] last;
        logic             seen;
    } st_t;

    st_t s_d, s_q;
    logic            changed;
    logic [ACC_W:0]  sum;

    always_comb begin
        changed = !s_q.seen || (idx != s_q.last);
        charge  = {1'b0, base_cost} + (changed ? {1'b0, ovh_cost} : '0);
        sum     = {1'b0, s_q.acc} + (ACC_W+1)'(charge);
        s_d     = s_q;
        if (valid) begin
            s_d.acc  = sum[ACC_W] ? '1 : sum[ACC_W-1:0];
            s_d.last = idx;
            s_d.seen = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign acc = s_q.acc;
endmodule

// File: rtl/energy_avg_div.sv
module energy_avg_div #(
    parameter int ACC_W = 40,
    parameter int CNT_W = 32,
    parameter int CPD_W = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   start,
    input  logic [ACC_W-1:0]       dividend,
    input  logic [CNT_W-1:0]       divisor,
    input  logic [CPD_W-1:0]       cpd,
    output logic                   busy,
    output logic                   done,
    output logic [ACC_W-1:0]       quotient,
    output logic [ACC_W+CPD_W-1:0] datum
);
    localparam int STEP_W = $clog2(ACC_W + 1);
    localparam int DAT_W  = ACC_W + CPD_W;

    typedef struct packed {
        logic              busy;
        logic              done;
        logic [ACC_W-1:0]  work;
        logic [CNT_W-1:0]  rem;
        logic [CNT_W-1:0]  dvs;
        logic [CPD_W-1:0]  cpd;
        logic [STEP_W-1:0] steps;
        logic [ACC_W-1:0]  quo;
        logic [DAT_W-1:0]  datum;
    } st_t;

    st_t s_d, s_q;
    logic [CNT_W:0]   trial;
    logic [CNT_W:0]   diff;
    logic [ACC_W-1:0] work_n;

    always_comb begin
        s_d    = s_q;
        trial  = {s_q.rem, s_q.work[ACC_W-1]};
        diff   = trial - {1'b0, s_q.dvs};
        work_n = {s_q.work[ACC_W-2:0], 1'b0};
        if (s_q.busy) begin
            if (trial >= {1'b0, s_q.dvs}) begin
                s_d.rem   = diff[CNT_W-1:0];
                work_n[0] = 1'b1;
            end else begin
                s_d.rem = trial[CNT_W-1:0];
            end
            s_d.work  = work_n;
            s_d.steps = s_q.steps - 1'b1;
            if (s_q.steps == STEP_W'(1)) begin
                s_d.busy  = 1'b0;
                s_d.done  = 1'b1;
                s_d.quo   = work_n;
                s_d.datum = DAT_W'(work_n) * DAT_W'(s_q.cpd);
            end
        end else if (start) begin
            s_d.done = 1'b0;
            s_d.cpd  = cpd;
            if (divisor == '0) begin
                s_d.quo   = '0;
                s_d.datum = '0;
                s_d.done  = 1'b1;
            end else begin
                s_d.busy  = 1'b1;
                s_d.work  = dividend;
                s_d.rem   = '0;
                s_d.dvs   = divisor;
                s_d.steps = STEP_W'(ACC_W);
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy     = s_q.busy;
    assign done     = s_q.done;
    assign quotient = s_q.quo;
    assign datum    = s_q.datum;
endmodule

// File: rtl/insn_energy_meter.sv
module insn_energy_meter
    import energy_pkg::*;
#(
    parameter int KEY_W  = 4,
    parameter int COST_W = 16,
    parameter int ACC_W  = 40,
    parameter int CNT_W  = 32,
    parameter int CPD_W  = 8
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   in_valid,
    input  logic                   arith_present,
    input  logic [KEY_W-1:0]       arith_key,
    input  logic [KEY_W-1:0]       move_key,
    input  logic                   tbl_we,
    input  logic [1:0]             tbl_unit,
    input  logic                   tbl_kind,
    input  logic [KEY_W:0]         tbl_addr,
    input  logic [COST_W-1:0]      tbl_data,
    input  logic                   avg_start,
    input  logic [CPD_W-1:0]       cyc_per_datum,
    output logic [ACC_W-1:0]       energy_alu,
    output logic [ACC_W-1:0]       energy_agu,
    output logic [ACC_W-1:0]       energy_pcu,
    output logic [ACC_W-1:0]       energy_oth,
    output logic [ACC_W-1:0]       energy_total,
    output logic [CNT_W-1:0]       cycle_count,
    output logic                   avg_busy,
    output logic                   avg_done,
    output logic [ACC_W-1:0]       avg_energy,
    output logic [ACC_W+CPD_W-1:0] datum_energy
);
    localparam int IDX_W = KEY_W + 1;
    localparam int SUM_W = COST_W + 3;

    logic [IDX_W-1:0]  arith_idx, move_idx;
    logic [IDX_W-1:0]  unit_idx    [NUM_UNITS];
    logic [COST_W-1:0] unit_base   [NUM_UNITS];
    logic [COST_W-1:0] unit_ovh    [NUM_UNITS];
    logic [COST_W:0]   unit_charge [NUM_UNITS];
    logic [ACC_W-1:0]  unit_acc    [NUM_UNITS];

    // R4/R5: index formation, top bit marks move-part fallback
    assign arith_idx = arith_present ? {1'b0, arith_key} : {1'b1, move_key};
    assign move_idx  = {1'b0, move_key};

    for (genvar u = 0; u < NUM_UNITS; u++) begin : g_unit
        if (uses_arith(u)) begin : g_arith
            assign unit_idx[u] = arith_idx;
        end else begin : g_move
            assign unit_idx[u] = move_idx;
        end

        energy_cost_table #(.IDX_W(IDX_W), .COST_W(COST_W)) u_tbl (
            .clk       (clk),
            .rst_n     (rst_n),
            .we        (tbl_we && (tbl_unit == 2'(u))),
            .kind      (tbl_kind),
            .waddr     (tbl_addr),
            .wdata     (tbl_data),
            .raddr     (unit_idx[u]),
            .base_cost (unit_base[u]),
            .ovh_cost  (unit_ovh[u])
        );

        energy_unit_acc #(.IDX_W(IDX_W), .COST_W(COST_W), .ACC_W(ACC_W)) u_acc (
            .clk       (clk),
            .rst_n     (rst_n),
            .valid     (in_valid),
            .idx       (unit_idx[u]),
            .base_cost (unit_base[u]),
            .ovh_cost  (unit_ovh[u]),
            .charge    (unit_charge[u]),
            .acc       (unit_acc[u])
        );
    end

    assign energy_alu = unit_acc[UNIT_ALU];
    assign energy_agu = unit_acc[UNIT_AGU];
    assign energy_pcu = unit_acc[UNIT_PCU];
    assign energy_oth = unit_acc[UNIT_OTH];

    typedef struct packed {
        logic [ACC_W-1:0] total;
        logic [CNT_W-1:0] count;
    } top_t;

    top_t s_d, s_q;
    logic [SUM_W-1:0] cyc_sum;
    logic [ACC_W:0]   tot_sum;

    always_comb begin
        cyc_sum = '0;
        for (int u = 0; u < NUM_UNITS; u++) begin
            cyc_sum = cyc_sum + SUM_W'(unit_charge[u]);
        end
        tot_sum = {1'b0, s_q.total} + (ACC_W+1)'(cyc_sum);
        s_d     = s_q;
        if (in_valid) begin
            s_d.total = tot_sum[ACC_W] ? '1 : tot_sum[ACC_W-1:0];
            if (s_q.count != '1) s_d.count = s_q.count + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign energy_total = s_q.total;
    assign cycle_count  = s_q.count;

    energy_avg_div #(.ACC_W(ACC_W), .CNT_W(CNT_W), .CPD_W(CPD_W)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (avg_start),
        .dividend (s_q.total),
        .divisor  (s_q.count),
        .cpd      (cyc_per_datum),
        .busy     (avg_busy),
        .done     (avg_done),
        .quotient (avg_energy),
        .datum    (datum_energy)
    );
endmodule

// File: rtl/energy_meter_checker.sv
module energy_meter_checker #(
    parameter int ACC_W = 40,
    parameter int CNT_W = 32
) (
    input logic             clk,
    input logic             rst_n,
    input logic             in_valid,
    input logic             avg_start,
    input logic             avg_busy,
    input logic             avg_done,
    input logic [ACC_W-1:0] energy_alu,
    input logic [ACC_W-1:0] energy_agu,
    input logic [ACC_W-1:0] energy_pcu,
    input logic [ACC_W-1:0] energy_oth,
    input logic [ACC_W-1:0] energy_total,
    input logic [CNT_W-1:0] cycle_count,
    input logic [ACC_W-1:0] avg_energy
);
    p_idle_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> $stable(energy_total) && $stable(cycle_count));

    p_count_step_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && cycle_count != '1) |=> cycle_count == $past(cycle_count) + 1'b1);

    p_total_dominates_r7: assert property (@(posedge clk) disable iff (!rst_n)
        energy_total >= energy_alu && energy_total >= energy_agu &&
        energy_total >= energy_pcu && energy_total >= energy_oth);

    p_no_wrap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        1'b1 |=> energy_total >= $past(energy_total));

    p_sat_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
        energy_total == '1 |=> energy_total == '1);

    p_busy_done_excl_r10: assert property (@(posedge clk) disable iff (!rst_n)
        !(avg_busy && avg_done));

    p_result_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (avg_done && !avg_start) |=> avg_done && $stable(avg_energy));
endmodule

bind insn_energy_meter energy_meter_checker #(.ACC_W(ACC_W), .CNT_W(CNT_W)) u_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .in_valid     (in_valid),
    .avg_start    (avg_start),
    .avg_busy     (avg_busy),
    .avg_done     (avg_done),
    .energy_alu   (energy_alu),
    .energy_agu   (energy_agu),
    .energy_pcu   (energy_pcu),
    .energy_oth   (energy_oth),
    .energy_total (energy_total),
    .cycle_count  (cycle_count),
    .avg_energy   (avg_energy)
);

// File: tb/insn_energy_meter_test.sv
`timescale 1ns/1ps
module insn_energy_meter_test;
    localparam int KEY_W  = 2;
    localparam int COST_W = 16;
    localparam int ACC_W  = 24;
    localparam int CNT_W  = 16;
    localparam int CPD_W  = 4;
    localparam int NIDX   = 1 << (KEY_W + 1);
    localparam longint AMAX = (64'd1 << ACC_W) - 1;
    localparam longint CMAX = (64'd1 << CNT_W) - 1;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic in_valid = 1'b0, arith_present = 1'b0;
    logic [KEY_W-1:0] arith_key = '0, move_key = '0;
    logic tbl_we = 1'b0, tbl_kind = 1'b0;
    logic [1:0] tbl_unit = '0;
    logic [KEY_W:0] tbl_addr = '0;
    logic [COST_W-1:0] tbl_data = '0;
    logic avg_start = 1'b0;
    logic [CPD_W-1:0] cyc_per_datum = 4'd7;
    logic [ACC_W-1:0] e_alu, e_agu, e_pcu, e_oth, e_tot, avg_e;
    logic [CNT_W-1:0] cnt;
    logic busy, done;
    logic [ACC_W+CPD_W-1:0] datum_e;

    always #5 clk = ~clk;

    insn_energy_meter #(.KEY_W(KEY_W), .COST_W(COST_W), .ACC_W(ACC_W),
                        .CNT_W(CNT_W), .CPD_W(CPD_W)) uut (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .arith_present(arith_present),
        .arith_key(arith_key), .move_key(move_key), .tbl_we(tbl_we), .tbl_unit(tbl_unit),
        .tbl_kind(tbl_kind), .tbl_addr(tbl_addr), .tbl_data(tbl_data), .avg_start(avg_start),
        .cyc_per_datum(cyc_per_datum), .energy_alu(e_alu), .energy_agu(e_agu),
        .energy_pcu(e_pcu), .energy_oth(e_oth), .energy_total(e_tot), .cycle_count(cnt),
        .avg_busy(busy), .avg_done(done), .avg_energy(avg_e), .datum_energy(datum_e)
    );

    int checks = 0, failures = 0;
    bit finished = 1'b0;
    longint base_m [4][NIDX];
    longint ovh_m  [4][NIDX];
    longint eu [4];
    longint et, ec;
    int  last_m [4];
    bit  seen_m [4];

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint unit_out(input int u);
        case (u)
            0: return longint'(e_alu);
            1: return longint'(e_agu);
            2: return longint'(e_pcu);
            default: return longint'(e_oth);
        endcase
    endfunction

    task automatic check_all(input string req);
        for (int u = 0; u < 4; u++) chk(unit_out(u) == eu[u], req, unit_out(u), eu[u]);
        chk(longint'(e_tot) == et, {req, " R7 total"}, longint'(e_tot), et);
        chk(longint'(cnt) == ec, {req, " R7 count"}, longint'(cnt), ec);
    endtask

    task automatic model_clear();
        for (int u = 0; u < 4; u++) begin
            eu[u] = 0; seen_m[u] = 0; last_m[u] = 0;
            for (int i = 0; i < NIDX; i++) begin base_m[u][i] = 0; ovh_m[u][i] = 0; end
        end
        et = 0; ec = 0;
    endtask

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (2) @(posedge clk);
        @(negedge clk); rst_n = 1'b1;
        model_clear();
    endtask

    task automatic wr(input int u, input int kind, input int addr, input int data);
        @(negedge clk);
        tbl_we = 1'b1; tbl_unit = 2'(u); tbl_kind = kind[0];
        tbl_addr = (KEY_W+1)'(addr); tbl_data = COST_W'(data);
        @(posedge clk); #2;
        tbl_we = 1'b0;
        if (kind == 1) ovh_m[u][addr] = data; else base_m[u][addr] = data;
    endtask

    task automatic step(input bit v, input int p, input int a, input int m, input string req);
        longint c, sum;
        int idx;
        @(negedge clk);
        in_valid = v; arith_present = p[0];
        arith_key = KEY_W'(a); move_key = KEY_W'(m);
        @(posedge clk); #2;
        in_valid = 1'b0;
        if (v) begin
            sum = 0;
            for (int u = 0; u < 4; u++) begin
                if (u == 0 || u == 2) idx = p ? a : ((1 << KEY_W) + m);
                else idx = m;
                c = base_m[u][idx];
                if (!seen_m[u] || idx != last_m[u]) c += ovh_m[u][idx];
                seen_m[u] = 1; last_m[u] = idx;
                eu[u] = (eu[u] + c > AMAX) ? AMAX : eu[u] + c;
                sum += c;
            end
            et = (et + sum > AMAX) ? AMAX : et + sum;
            ec = (ec + 1 > CMAX) ? CMAX : ec + 1;
        end
        check_all(req);
    endtask

    task automatic run_avg(input string req);
        longint q;
        int waited;
        q = (ec == 0) ? 0 : et / ec;
        @(negedge clk); avg_start = 1'b1;
        @(posedge clk); #2; avg_start = 1'b0;
        waited = 0;
        while (!done && waited < 200) begin @(negedge clk); waited++; end
        chk(done == 1'b1, {req, " done"}, longint'(done), 1);
        chk(longint'(avg_e) == q, {req, " R10 avg"}, longint'(avg_e), q);
        chk(longint'(datum_e) == q * 7, {req, " R11 datum"}, longint'(datum_e), q * 7);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            failures++; checks++;
            $display("FAIL watchdog expired actual=0 expected=1");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_clear();
        do_reset();
        // R1: reset state
        #2;
        check_all("R1");
        chk(busy == 0 && done == 0, "R1 divider idle", longint'({busy, done}), 0);
        chk(avg_e == 0 && datum_e == 0, "R1 results", longint'(avg_e), 0);
        // R1: tables zero, so a counted cycle charges nothing
        step(1, 1, 1, 2, "R1 zero tables");

        do_reset();
        // R9: load all tables
        for (int u = 0; u < 4; u++)
            for (int i = 0; i < NIDX; i++) begin
                wr(u, 0, i, u * 37 + i * 5 + 3);
                wr(u, 1, i, i * 11 + u * 7 + 20);
            end
        // R2 R3 R4 R5: every ordered pair of descriptors
        for (int pv = 0; pv < 32; pv++)
            for (int cu = 0; cu < 32; cu++) begin
                step(1, pv >> 4, (pv >> 2) & 3, pv & 3, "R2 R3 sweep");
                step(1, cu >> 4, (cu >> 2) & 3, cu & 3, "R2 R3 sweep");
            end
        // R4: same number, arithmetic vs move source
        step(1, 1, 1, 0, "R4 arith key 1");
        step(1, 0, 0, 1, "R4 move fallback 1");
        // R5: arithmetic changes leave move-indexed units at base cost
        step(1, 1, 2, 3, "R5 prep");
        step(1, 1, 0, 3, "R5 arith ignored");
        // R6: invalid cycles with other keys are ignored
        step(0, 0, 3, 0, "R6 invalid");
        step(0, 1, 2, 1, "R6 invalid");
        step(1, 1, 0, 3, "R6 history kept");
        // R9: overwrite live entry
        wr(0, 0, 0, 5000);
        step(1, 1, 0, 3, "R9 new base");
        // R10 R11: average and datum
        run_avg("R10 R11");
        // R10: start while busy is ignored
        @(negedge clk); avg_start = 1'b1;
        @(posedge clk); #2; avg_start = 1'b0;
        @(negedge clk); avg_start = 1'b1;
        @(posedge clk); #2; avg_start = 1'b0;
        while (busy) @(negedge clk);
        chk(longint'(avg_e) == et / ec, "R10 busy start ignored", longint'(avg_e), et / ec);

        // R10: zero count gives zero
        do_reset();
        run_avg("R10 zero count");

        // R8: saturation with maximum costs
        for (int u = 0; u < 4; u++)
            for (int i = 0; i < NIDX; i++) begin
                wr(u, 0, i, 65535);
                wr(u, 1, i, 65535);
            end
        for (int k = 0; k < 140; k++)
            step(1, k & 1, k & 3, (k >> 1) & 3, "R8 saturate");
        chk(longint'(e_tot) == AMAX, "R8 total at max", longint'(e_tot), AMAX);
        chk(longint'(e_alu) == AMAX, "R8 unit at max", longint'(e_alu), AMAX);

        finished = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule